// File: doc/BRIEF.md
# Bit-Stuffed NRZI Line Receiver

This block turns a serial line that carries NRZI-coded, bit-stuffed data back into bytes. A system-clock enable marks the cycle in which the line holds a valid symbol; the serial rate is normally one quarter of the system clock. On each such cycle the line is sampled and compared with the sample before it. Equal samples give a recovered one and a change gives a recovered zero. The line rests high while idle, and the first low sample marks the start of a transmission. That marker symbol only starts the link and carries no data.

The sender inserts a zero after every run of six recovered ones so that the line keeps changing. Once the link is active, the receiver counts consecutive recovered ones. The symbol that follows a full run is dropped: it does not enter the shift register, and the block raises a one-cycle pause flag for it. Every other recovered bit shifts into an eight-bit register, least significant bit first. A strobe marks each completed byte.

Top module: `nrzi_unstuff_rx`

## Requirements
- R1: While reset is high and in the first cycle after it, `rx_byte` is 0 and `byte_vld`, `bit_vld` and `stuff_pause` are all 0.
- R2: Until the first enabled sample that reads 0, the block stays idle and raises no `bit_vld`, `stuff_pause` or `byte_vld`. The low marker sample itself delivers no bit.
- R3: A recovered bit is 1 when the enabled line sample equals the previous enabled sample and 0 when it differs. The previous sample is 1 after reset and is updated on every enabled sample, the marker included.
- R4: In the cycle after each enabled sample in the active link that is accepted, `bit_vld` is 1 for exactly one cycle.
- R5: After six consecutive accepted ones, the next enabled sample is dropped. `stuff_pause` pulses in the following cycle and `bit_vld` does not. The dropped bit is neither shifted nor counted toward the byte, and the run count restarts.
- R6: Bytes are assembled least significant bit first: the first accepted bit of a byte lands in `rx_byte[0]` and the eighth in `rx_byte[7]`.
- R7: `byte_vld` pulses for one cycle, together with `bit_vld`, in the cycle after the eighth accepted bit of a byte. `rx_byte` then holds that byte until the next strobe.
- R8: While `bit_en` is low, `line_in` has no effect on any output or on later decoding.
- R9: An accepted zero clears the run of ones, so five ones followed by a zero produce no pause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | One-cycle enable marking a valid line symbol |
| line_in | input | 1 | NRZI serial line, idle high |
| rx_byte | output | 8 | Last completed byte |
| byte_vld | output | 1 | One-cycle strobe for a new `rx_byte` |
| bit_vld | output | 1 | One-cycle strobe for each accepted bit |
| stuff_pause | output | 1 | One-cycle strobe for each dropped stuffed bit |

## Verification
The stream starts with an idle stretch and line toggles made while the enable is low. It then carries two bytes of all ones, which stuff twice, including across a byte boundary. Next come a zero byte, a byte with exactly six leading ones, and a byte with five ones and then a zero; these last two separate the stuff threshold from an off-by-one. A sweep of all 256 byte values runs on one continuous stream, so runs of ones carry across byte edges. Each received byte is compared with what the bench's own encoder sent. The numbers of pauses and accepted bits are compared with the stuff count and the bit count that the encoder predicts.

// File: rtl/nrzi_rx_pkg.sv
package nrzi_rx_pkg;

  typedef enum logic {
    LINK_IDLE   = 1'b0,
    LINK_ACTIVE = 1'b1
  } link_state_e;

  // recovered bit: one when no transition between samples
  function automatic logic nrzi_bit(input logic prev_s, input logic cur_s);
    return ~(prev_s ^ cur_s);
  endfunction

endpackage

// File: rtl/nrzi_line_sampler.sv
module nrzi_line_sampler
  import nrzi_rx_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic line_in,
  output logic dec_bit,
  output logic prev_sample
);

  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b1;
    end else if (bit_en) begin
      prev_q <= line_in;
    end
  end

  always_comb begin
    dec_bit = nrzi_bit(prev_q, line_in);
  end

  assign prev_sample = prev_q;

endmodule

// File: rtl/nrzi_stuff_tracker.sv
module nrzi_stuff_tracker
  import nrzi_rx_pkg::*;
#(
  parameter int STUFF_RUN = 6,
  localparam int RUN_W = $clog2(STUFF_RUN + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_en,
  input  logic             line_in,
  input  logic             dec_bit,
  output logic             link_active,
  output logic [RUN_W-1:0] run_cnt,
  output logic             take_bit,
  output logic             drop_bit
);

  link_state_e      state_q;
  logic [RUN_W-1:0] run_q;
  logic             run_full;

  assign run_full    = (run_q == RUN_W'(STUFF_RUN));
  assign link_active = (state_q == LINK_ACTIVE);

  always_comb begin
    take_bit = 1'b0;
    drop_bit = 1'b0;
    if (bit_en && state_q == LINK_ACTIVE) begin
      if (run_full) drop_bit = 1'b1;
      else          take_bit = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= LINK_IDLE;
    end else if (state_q == LINK_IDLE && bit_en && !line_in) begin
      state_q <= LINK_ACTIVE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= '0;
    end else if (drop_bit) begin
      run_q <= '0;
    end else if (take_bit) begin
      run_q <= dec_bit ? run_q + 1'b1 : '0;
    end
  end

  assign run_cnt = run_q;

endmodule

// File: rtl/nrzi_byte_assembler.sv
module nrzi_byte_assembler #(
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take_bit,
  input  logic              drop_bit,
  input  logic              dec_bit,
  output logic [DATA_W-1:0] rx_byte,
  output logic              byte_vld,
  output logic              bit_vld,
  output logic              stuff_pause,
  output logic [CNT_W-1:0]  bit_idx
);

  logic [DATA_W-1:0] shift_q;
  logic [DATA_W-1:0] shift_nxt;
  logic [DATA_W-1:0] byte_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              last_bit;

  assign last_bit  = (cnt_q == CNT_W'(DATA_W - 1));
  assign shift_nxt = {dec_bit, shift_q[DATA_W-1:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      shift_q <= '0;
      cnt_q   <= '0;
      byte_q  <= '0;
    end else if (take_bit) begin
      shift_q <= shift_nxt;
      cnt_q   <= last_bit ? '0 : cnt_q + 1'b1;
      if (last_bit) byte_q <= shift_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_vld     <= 1'b0;
      stuff_pause <= 1'b0;
      byte_vld    <= 1'b0;
    end else begin
      bit_vld     <= take_bit;
      stuff_pause <= drop_bit;
      byte_vld    <= take_bit && last_bit;
    end
  end

  assign rx_byte = byte_q;
  assign bit_idx = cnt_q;

endmodule

// File: rtl/nrzi_unstuff_rx.sv
module nrzi_unstuff_rx #(
  parameter int DATA_W    = 8,
  parameter int STUFF_RUN = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  input  logic              line_in,
  output logic [DATA_W-1:0] rx_byte,
  output logic              byte_vld,
  output logic              bit_vld,
  output logic              stuff_pause
);

  localparam int RUN_W = $clog2(STUFF_RUN + 1);
  localparam int CNT_W = $clog2(DATA_W);

  logic             dec_bit;
  logic             prev_sample;
  logic             link_active;
  logic [RUN_W-1:0] run_cnt;
  logic             take_bit;
  logic             drop_bit;
  logic [CNT_W-1:0] bit_idx;

  nrzi_line_sampler u_sampler (
    .clk         (clk),
    .rst         (rst),
    .bit_en      (bit_en),
    .line_in     (line_in),
    .dec_bit     (dec_bit),
    .prev_sample (prev_sample)
  );

  nrzi_stuff_tracker #(.STUFF_RUN(STUFF_RUN)) u_tracker (
    .clk         (clk),
    .rst         (rst),
    .bit_en      (bit_en),
    .line_in     (line_in),
    .dec_bit     (dec_bit),
    .link_active (link_active),
    .run_cnt     (run_cnt),
    .take_bit    (take_bit),
    .drop_bit    (drop_bit)
  );

  nrzi_byte_assembler #(.DATA_W(DATA_W)) u_asm (
    .clk         (clk),
    .rst         (rst),
    .take_bit    (take_bit),
    .drop_bit    (drop_bit),
    .dec_bit     (dec_bit),
    .rx_byte     (rx_byte),
    .byte_vld    (byte_vld),
    .bit_vld     (bit_vld),
    .stuff_pause (stuff_pause),
    .bit_idx     (bit_idx)
  );

endmodule

// File: rtl/nrzi_unstuff_rx_chk.sv
module nrzi_unstuff_rx_chk #(
  parameter int DATA_W    = 8,
  parameter int STUFF_RUN = 6,
  localparam int RUN_W = $clog2(STUFF_RUN + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              bit_en,
  input logic [DATA_W-1:0] rx_byte,
  input logic              byte_vld,
  input logic              bit_vld,
  input logic              stuff_pause,
  input logic              link_active,
  input logic [RUN_W-1:0]  run_cnt
);

  p_vld_needs_en_r4: assert property (@(posedge clk) disable iff (rst)
    (bit_vld || stuff_pause) |-> $past(bit_en));

  p_vld_pause_excl_r5: assert property (@(posedge clk) disable iff (rst)
    !(bit_vld && stuff_pause));

  p_pause_after_run_r5: assert property (@(posedge clk) disable iff (rst)
    (bit_en && link_active && run_cnt == RUN_W'(STUFF_RUN)) |=> (stuff_pause && !bit_vld));

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(link_active) |-> (!bit_vld && !stuff_pause && !byte_vld));

  p_byte_single_r7: assert property (@(posedge clk) disable iff (rst)
    byte_vld |=> !byte_vld);

  p_byte_with_bit_r7: assert property (@(posedge clk) disable iff (rst)
    byte_vld |-> bit_vld);

  p_no_en_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !$past(bit_en) |-> ($stable(rx_byte) && !bit_vld && !stuff_pause));

endmodule

bind nrzi_unstuff_rx nrzi_unstuff_rx_chk #(
  .DATA_W    (DATA_W),
  .STUFF_RUN (STUFF_RUN)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .bit_en      (bit_en),
  .rx_byte     (rx_byte),
  .byte_vld    (byte_vld),
  .bit_vld     (bit_vld),
  .stuff_pause (stuff_pause),
  .link_active (link_active),
  .run_cnt     (run_cnt)
);

// File: tb/nrzi_unstuff_rx_test.sv
module nrzi_unstuff_rx_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bit_en = 1'b0;
  logic       line_in = 1'b1;
  logic [7:0] rx_byte;
  logic       byte_vld;
  logic       bit_vld;
  logic       stuff_pause;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic [7:0] exp_q [0:299];
  int ntx = 0;
  int nrx = 0;
  int nbits = 0;
  int npause = 0;
  logic prev_bv = 1'b0;

  logic enc_prev = 1'b1;
  int   enc_run = 0;
  int   exp_stuff = 0;

  always #5 clk = ~clk;

  nrzi_unstuff_rx uut (
    .clk         (clk),
    .rst         (rst),
    .bit_en      (bit_en),
    .line_in     (line_in),
    .rx_byte     (rx_byte),
    .byte_vld    (byte_vld),
    .bit_vld     (bit_vld),
    .stuff_pause (stuff_pause)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !finished) begin
      if (bit_vld) nbits++;
      if (stuff_pause) npause++;
      if (byte_vld) begin
        check(rx_byte == exp_q[nrx], "R3/R6 byte value", rx_byte, exp_q[nrx]);
        nrx++;
      end
      if (byte_vld && prev_bv) check(1'b0, "R7 strobe width", 2, 1);
      prev_bv = byte_vld;
    end
  end

  // one line symbol: enable for one clock, then three idle clocks
  task automatic send_sym(input logic v);
    @(negedge clk);
    line_in = v;
    bit_en = 1'b1;
    @(negedge clk);
    bit_en = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic send_nrz(input logic b);
    logic lv;
    lv = b ? enc_prev : ~enc_prev;
    enc_prev = lv;
    send_sym(lv);
  endtask

  task automatic send_byte(input logic [7:0] d);
    exp_q[ntx] = d;
    ntx++;
    for (int i = 0; i < 8; i++) begin
      send_nrz(d[i]);
      if (d[i]) enc_run++;
      else enc_run = 0;
      if (enc_run == 6) begin
        send_nrz(1'b0);
        enc_run = 0;
        exp_stuff++;
      end
    end
  endtask

  initial begin
    int p0;
    repeat (3) @(negedge clk);
    check(rx_byte == 8'h00 && !byte_vld && !bit_vld && !stuff_pause,
          "R1 outputs in reset", {rx_byte, byte_vld, bit_vld, stuff_pause}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(rx_byte == 8'h00 && !byte_vld && !bit_vld && !stuff_pause,
          "R1 outputs after reset", {rx_byte, byte_vld, bit_vld, stuff_pause}, 0);

    // idle line high with enables
    for (int i = 0; i < 10; i++) send_sym(1'b1);
    check(nbits == 0 && npause == 0 && nrx == 0, "R2 idle no strobes", nbits + npause + nrx, 0);

    // line toggles with enable low
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      line_in = i[0];
    end
    @(negedge clk);
    line_in = 1'b1;
    repeat (2) @(negedge clk);
    check(nbits == 0 && npause == 0 && rx_byte == 8'h00, "R8 toggles without enable",
          nbits + npause + rx_byte, 0);

    // start marker
    send_sym(1'b0);
    enc_prev = 1'b0;
    check(nbits == 0 && npause == 0, "R2 marker delivers no bit", nbits + npause, 0);

    send_byte(8'hFF);
    send_byte(8'hFF);
    check(npause == 2, "R5 two stuffs over two ones bytes", npause, 2);
    send_byte(8'h00);
    p0 = npause;
    send_byte(8'h3F);
    check(npause == p0 + 1, "R5 six ones stuffed", npause - p0, 1);
    p0 = npause;
    send_byte(8'h1F);
    check(npause == p0, "R9 five ones then zero not stuffed", npause - p0, 0);
    check(nrx == 5 && rx_byte == 8'h1F, "R6 held after last strobe", rx_byte, 8'h1F);

    for (int v = 0; v < 256; v++) send_byte(8'(v));
    repeat (8) @(negedge clk);

    check(nrx == ntx, "R7 byte strobe count", nrx, ntx);
    check(nbits == 8 * ntx, "R4 accepted bit count", nbits, 8 * ntx);
    check(npause == exp_stuff, "R5 pause count", npause, exp_stuff);
    check(rx_byte == 8'hFF, "R7 last byte held", rx_byte, 8'hFF);

    // enable-low toggles after data must not disturb held byte
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      line_in = ~line_in;
    end
    repeat (2) @(negedge clk);
    check(rx_byte == 8'hFF && nrx == ntx, "R8 held byte unchanged", rx_byte, 8'hFF);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      check(1'b0, "watchdog R7 run incomplete", nrx, ntx);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule